// File: doc/BRIEF.md
# Serial Channel Error Status Unit

This unit keeps the protocol-error state for a group of serial-bus channels. Each channel is given one of six kinds: control transmit, control receive, async transmit, async receive, synchronous or isochronous. For every channel it holds a read status word, a write status word and one summary bit in a channel status vector. An error event from the channel engine ORs flag bits into the two words and raises the channel's summary bit.

Software clears state by writing zeros: a zero bit clears the matching bit and a one bit leaves it as it was. The kind of a channel decides which word bits count as halting errors. A channel stays halted while any of those bits is set. A single interrupt output is the OR of all summary bits whose channel kind has its interrupt enable set.

Top module: `chan_err_status`

## Requirements
- R1: After reset every status word, every summary bit and every interrupt enable is zero, and every channel kind is 0 (control transmit). As a result `irq` is 0 and `halted` is all zeros.
- R2: When `ev_valid` is high, the channel `ev_ch` gets `ev_rset` ORed into its read word and `ev_wset` ORed into its write word, and its bit in `ch_status` is set. All of this is visible after the next rising edge.
- R3: A `cs_we` cycle clears each `ch_status` bit whose `cs_wdata` bit is 0 and leaves each bit whose `cs_wdata` bit is 1. If an event sets a bit in the same cycle, the set wins.
- R4: An `sw_we` cycle ANDs `sw_rmask` into the read word and `sw_wmask` into the write word of channel `sw_ch`. Zero bits clear and one bits keep. Event bits that arrive in the same cycle win.
- R5: Kind codes are 0 control transmit, 1 control receive, 2 async transmit, 3 async receive, 4 synchronous and 5 isochronous. Enable bit k of `ien_wdata` belongs to kind k. `irq` is high exactly when some channel has its `ch_status` bit set and the enable for its kind is set. Codes 6 and 7 never interrupt.
- R6: A synchronous channel is halted exactly when bit 3 of its write word is set.
- R7: An isochronous channel is halted while bit 2 or bit 1 of its write word is set.
- R8: An async or control channel is halted while bit 4 or bit 2 of its read word or of its write word is set. Other bits, and channels of kind 6 or 7, never halt.
- R9: A channel's `halted` bit follows the stored words and kind. It falls right after the edge that stores the write clearing the last halting bit.
- R10: `rd_rsts`, `rd_wsts` and `rd_kind` show, without delay, the stored words and kind of channel `rd_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write a channel kind |
| cfg_ch | input | CH_W | Channel whose kind is written |
| cfg_kind | input | 3 | Kind code |
| ien_we | input | 1 | Write interrupt enables |
| ien_wdata | input | 6 | One enable per kind |
| ev_valid | input | 1 | Error event strobe |
| ev_ch | input | CH_W | Channel of the event |
| ev_rset | input | 8 | Bits set in the read word |
| ev_wset | input | 8 | Bits set in the write word |
| cs_we | input | 1 | Write to the summary vector |
| cs_wdata | input | NCH | Zero clears, one keeps |
| sw_we | input | 1 | Write to one channel's words |
| sw_ch | input | CH_W | Channel whose words are written |
| sw_rmask | input | 8 | Zero-to-clear data for the read word |
| sw_wmask | input | 8 | Zero-to-clear data for the write word |
| rd_ch | input | CH_W | Channel selected for readback |
| rd_rsts | output | 8 | Read word of `rd_ch` |
| rd_wsts | output | 8 | Write word of `rd_ch` |
| rd_kind | output | 3 | Kind of `rd_ch` |
| ch_status | output | NCH | Per-channel summary bits |
| halted | output | NCH | Per-channel halt flags |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong word or kind register shows up as a wrong `halted` bit right after the edge that stores it. For example, a channel might keep running with a halting bit set, or stay halted after a clear. The wrong value can also be read back at once through the readback port. A faulty summary bit or enable shows on `irq` in the same cycle. The bench therefore sets up channel kinds and enables, then compares `ch_status`, `irq` and `halted` after every edge. The sequences mix single-bit clears, one-keeps writes, set-versus-clear collisions and the unused kind codes.

// File: rtl/sces_pkg.sv
package sces_pkg;
    localparam int SW     = 8;
    localparam int KIND_W = 3;
    localparam int NKIND  = 6;

    typedef enum logic [KIND_W-1:0] {
        K_CTL_TX = 3'd0,
        K_CTL_RX = 3'd1,
        K_ASY_TX = 3'd2,
        K_ASY_RX = 3'd3,
        K_SYNC   = 3'd4,
        K_ISO    = 3'd5
    } kind_e;

    localparam logic [SW-1:0] PKT_HALT  = 8'h14;  // bits 4 and 2
    localparam logic [SW-1:0] SYNC_HALT = 8'h08;  // bit 3
    localparam logic [SW-1:0] ISO_HALT  = 8'h06;  // bits 2:1

    function automatic logic [SW-1:0] rd_halt_mask(logic [KIND_W-1:0] k);
        logic [SW-1:0] m;
        case (k)
            K_CTL_TX, K_CTL_RX, K_ASY_TX, K_ASY_RX: m = PKT_HALT;
            default:                                m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [SW-1:0] wr_halt_mask(logic [KIND_W-1:0] k);
        logic [SW-1:0] m;
        case (k)
            K_CTL_TX, K_CTL_RX, K_ASY_TX, K_ASY_RX: m = PKT_HALT;
            K_SYNC:                                 m = SYNC_HALT;
            K_ISO:                                  m = ISO_HALT;
            default:                                m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/sces_cfg.sv
module sces_cfg
    import sces_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CH_W-1:0]               cfg_ch,
    input  logic [KIND_W-1:0]             cfg_kind,
    input  logic                          ien_we,
    input  logic [NKIND-1:0]              ien_wdata,
    output logic [NCH-1:0][KIND_W-1:0]    kind,
    output logic [NKIND-1:0]              ien
);
    typedef struct packed {
        logic [NCH-1:0][KIND_W-1:0] kind;
        logic [NKIND-1:0]           ien;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int c = 0; c < NCH; c++) begin
            if (cfg_we && cfg_ch == CH_W'(c)) begin
                cfg_d.kind[c] = cfg_kind;
            end
        end
        if (ien_we) begin
            cfg_d.ien = ien_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign kind = cfg_q.kind;
    assign ien  = cfg_q.ien;
endmodule

// File: rtl/sces_chan.sv
module sces_chan
    import sces_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] kind,
    input  logic              ev_hit,
    input  logic [SW-1:0]     ev_rset,
    input  logic [SW-1:0]     ev_wset,
    input  logic              sw_hit,
    input  logic [SW-1:0]     sw_rmask,
    input  logic [SW-1:0]     sw_wmask,
    input  logic              cs_we,
    input  logic              cs_keep,
    output logic [SW-1:0]     rsts,
    output logic [SW-1:0]     wsts,
    output logic              stat,
    output logic              halt
);
    typedef struct packed {
        logic [SW-1:0] rsts;
        logic [SW-1:0] wsts;
        logic          stat;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // write-zero-to-clear first, so a same-cycle event wins
        if (sw_hit) begin
            st_d.rsts = st_d.rsts & sw_rmask;
            st_d.wsts = st_d.wsts & sw_wmask;
        end
        if (cs_we) begin
            st_d.stat = st_d.stat & cs_keep;
        end
        if (ev_hit) begin
            st_d.rsts = st_d.rsts | ev_rset;
            st_d.wsts = st_d.wsts | ev_wset;
            st_d.stat = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsts = st_q.rsts;
    assign wsts = st_q.wsts;
    assign stat = st_q.stat;
    assign halt = (|(st_q.rsts & rd_halt_mask(kind))) |
                  (|(st_q.wsts & wr_halt_mask(kind)));
endmodule

// File: rtl/sces_irq.sv
module sces_irq
    import sces_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0]              stat,
    input  logic [NCH-1:0][KIND_W-1:0]  kind,
    input  logic [NKIND-1:0]            ien,
    output logic                        irq
);
    logic [NCH-1:0] armed;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            armed[c] = 1'b0;
            for (int k = 0; k < NKIND; k++) begin
                if (kind[c] == KIND_W'(k)) begin
                    armed[c] = ien[k];
                end
            end
        end
    end

    assign irq = |(stat & armed);
endmodule

// File: rtl/chan_err_status.sv
module chan_err_status
    import sces_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CH_W-1:0]      cfg_ch,
    input  logic [KIND_W-1:0]    cfg_kind,
    input  logic                 ien_we,
    input  logic [NKIND-1:0]     ien_wdata,
    input  logic                 ev_valid,
    input  logic [CH_W-1:0]      ev_ch,
    input  logic [SW-1:0]        ev_rset,
    input  logic [SW-1:0]        ev_wset,
    input  logic                 cs_we,
    input  logic [NCH-1:0]       cs_wdata,
    input  logic                 sw_we,
    input  logic [CH_W-1:0]      sw_ch,
    input  logic [SW-1:0]        sw_rmask,
    input  logic [SW-1:0]        sw_wmask,
    input  logic [CH_W-1:0]      rd_ch,
    output logic [SW-1:0]        rd_rsts,
    output logic [SW-1:0]        rd_wsts,
    output logic [KIND_W-1:0]    rd_kind,
    output logic [NCH-1:0]       ch_status,
    output logic [NCH-1:0]       halted,
    output logic                 irq
);
    logic [NCH-1:0][KIND_W-1:0] kind;
    logic [NKIND-1:0]           ien;
    logic [NCH-1:0][SW-1:0]     rsts_all;
    logic [NCH-1:0][SW-1:0]     wsts_all;

    sces_cfg #(.NCH(NCH), .CH_W(CH_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_kind  (cfg_kind),
        .ien_we    (ien_we),
        .ien_wdata (ien_wdata),
        .kind      (kind),
        .ien       (ien)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        sces_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .kind     (kind[c]),
            .ev_hit   (ev_valid && ev_ch == CH_W'(c)),
            .ev_rset  (ev_rset),
            .ev_wset  (ev_wset),
            .sw_hit   (sw_we && sw_ch == CH_W'(c)),
            .sw_rmask (sw_rmask),
            .sw_wmask (sw_wmask),
            .cs_we    (cs_we),
            .cs_keep  (cs_wdata[c]),
            .rsts     (rsts_all[c]),
            .wsts     (wsts_all[c]),
            .stat     (ch_status[c]),
            .halt     (halted[c])
        );
    end

    sces_irq #(.NCH(NCH)) u_irq (
        .stat (ch_status),
        .kind (kind),
        .ien  (ien),
        .irq  (irq)
    );

    always_comb begin
        rd_rsts = '0;
        rd_wsts = '0;
        rd_kind = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_ch == CH_W'(c)) begin
                rd_rsts = rsts_all[c];
                rd_wsts = wsts_all[c];
                rd_kind = kind[c];
            end
        end
    end
endmodule

// File: rtl/chan_err_status_chk.sv
module chan_err_status_chk
    import sces_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [CH_W-1:0]   ev_ch,
    input logic              cs_we,
    input logic [NCH-1:0]    cs_wdata,
    input logic              sw_we,
    input logic [CH_W-1:0]   sw_ch,
    input logic [SW-1:0]     sw_rmask,
    input logic [SW-1:0]     sw_wmask,
    input logic [NCH-1:0]    ch_status,
    input logic [NCH-1:0]    halted,
    input logic              irq
);
    logic            zero_wr_q;
    logic [CH_W-1:0] zero_ch_q;
    logic            ev_q;
    logic [CH_W-1:0] ev_ch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_wr_q <= 1'b0;
            zero_ch_q <= '0;
            ev_q      <= 1'b0;
            ev_ch_q   <= '0;
        end else begin
            zero_wr_q <= sw_we && sw_rmask == '0 && sw_wmask == '0 &&
                         !(ev_valid && ev_ch == sw_ch);
            zero_ch_q <= sw_ch;
            ev_q      <= ev_valid;
            ev_ch_q   <= ev_ch;
        end
    end

    // R2: an event leaves the channel's summary bit set
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q |-> ch_status[ev_ch_q]);

    // R3: zero bits clear when no event collides
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_we && !ev_valid) |=> ((ch_status & ~$past(cs_wdata)) == '0));

    // R3: one bits keep their value
    p_keep_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_we && !ev_valid) |=>
        ((ch_status & $past(cs_wdata)) == ($past(ch_status) & $past(cs_wdata))));

    // R5: no interrupt without a pending summary bit
    p_irq_needs_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|ch_status));

    // R9: clearing all word bits releases the halt at once
    p_halt_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr_q |-> !halted[zero_ch_q]);
endmodule

bind chan_err_status chan_err_status_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_ch     (ev_ch),
    .cs_we     (cs_we),
    .cs_wdata  (cs_wdata),
    .sw_we     (sw_we),
    .sw_ch     (sw_ch),
    .sw_rmask  (sw_rmask),
    .sw_wmask  (sw_wmask),
    .ch_status (ch_status),
    .halted    (halted),
    .irq       (irq)
);

// File: tb/sim_chan_err_status.sv
`timescale 1ns/1ps
module sim_chan_err_status;
    localparam int NCH  = 8;
    localparam int CH_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic            cfg_we = 0, ien_we = 0, ev_valid = 0, cs_we = 0, sw_we = 0;
    logic [CH_W-1:0] cfg_ch = 0, ev_ch = 0, sw_ch = 0, rd_ch = 0;
    logic [2:0]      cfg_kind = 0;
    logic [5:0]      ien_wdata = 0;
    logic [7:0]      ev_rset = 0, ev_wset = 0, sw_rmask = 0, sw_wmask = 0;
    logic [NCH-1:0]  cs_wdata = 0;
    logic [7:0]      rd_rsts, rd_wsts;
    logic [2:0]      rd_kind;
    logic [NCH-1:0]  ch_status, halted;
    logic            irq;

    chan_err_status #(.NCH(NCH)) u0 (.*);

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cfg_we = 0; ien_we = 0; ev_valid = 0; cs_we = 0; sw_we = 0;
    endtask

    typedef struct packed {
        logic       ev;
        logic [2:0] evc;
        logic [7:0] rset;
        logic [7:0] wset;
        logic       cs;
        logic [7:0] csd;
        logic       sw;
        logic [2:0] swc;
        logic [7:0] swr;
        logic [7:0] sww;
        logic [7:0] est;
        logic       eirq;
        logic [7:0] ehalt;
    } vec_t;

    // kinds: ch0 ctl-tx, ch1 ctl-rx, ch2 asy-tx, ch3 asy-rx, ch4 sync, ch5 iso, ch6 sync, ch7 iso
    // enables: sync only (bit 4)
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1,3'd4,8'h00,8'h08, 1'b0,8'hFF, 1'b0,3'd0,8'hFF,8'hFF, 8'h10,1'b1,8'h10}, // R2 R6
        '{1'b1,3'd5,8'h00,8'h06, 1'b0,8'hFF, 1'b0,3'd0,8'hFF,8'hFF, 8'h30,1'b1,8'h30}, // R7
        '{1'b1,3'd2,8'h01,8'h00, 1'b0,8'hFF, 1'b0,3'd0,8'hFF,8'hFF, 8'h34,1'b1,8'h30}, // R8 bit0 no halt
        '{1'b0,3'd0,8'h00,8'h00, 1'b1,8'hEF, 1'b0,3'd0,8'hFF,8'hFF, 8'h24,1'b0,8'h30}, // R3 R5
        '{1'b0,3'd0,8'h00,8'h00, 1'b0,8'hFF, 1'b1,3'd4,8'hFF,8'hF7, 8'h24,1'b0,8'h20}, // R6 R9
        '{1'b1,3'd0,8'h00,8'h14, 1'b0,8'hFF, 1'b0,3'd0,8'hFF,8'hFF, 8'h25,1'b0,8'h21}, // R8
        '{1'b0,3'd0,8'h00,8'h00, 1'b0,8'hFF, 1'b1,3'd0,8'hFF,8'hFB, 8'h25,1'b0,8'h21}, // R8 bit4 left
        '{1'b0,3'd0,8'h00,8'h00, 1'b0,8'hFF, 1'b1,3'd0,8'hFF,8'hEF, 8'h25,1'b0,8'h20}, // R9
        '{1'b0,3'd0,8'h00,8'h00, 1'b0,8'hFF, 1'b1,3'd5,8'hFF,8'hFD, 8'h25,1'b0,8'h20}, // R7 bit2 left
        '{1'b0,3'd0,8'h00,8'h00, 1'b0,8'hFF, 1'b1,3'd5,8'hFF,8'hFB, 8'h25,1'b0,8'h00}, // R7 R9
        '{1'b1,3'd6,8'h00,8'h04, 1'b1,8'hBE, 1'b0,3'd0,8'hFF,8'hFF, 8'h64,1'b1,8'h00}, // R3 set wins, R6
        '{1'b0,3'd0,8'h00,8'h00, 1'b1,8'h00, 1'b0,3'd0,8'hFF,8'hFF, 8'h00,1'b0,8'h00}, // R3
        '{1'b1,3'd3,8'h10,8'h00, 1'b0,8'hFF, 1'b0,3'd0,8'hFF,8'hFF, 8'h08,1'b0,8'h08}, // R8 read word
        '{1'b0,3'd0,8'h00,8'h00, 1'b0,8'hFF, 1'b1,3'd3,8'hEF,8'hFF, 8'h08,1'b0,8'h00}, // R4 R9
        '{1'b1,3'd1,8'h04,8'h00, 1'b0,8'hFF, 1'b0,3'd0,8'hFF,8'hFF, 8'h0A,1'b0,8'h02}  // R8
    };

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20;
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ch_status", 32'(ch_status), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 halted", 32'(halted), 0);
        rd_ch = 3'd6;
        #1;
        chk("R1 kind", 32'(rd_kind), 0);
        chk("R1 words", {16'h0, rd_rsts, rd_wsts}, 0);

        @(posedge clk); #1;
        for (int c = 0; c < NCH; c++) begin
            cfg_we = 1; cfg_ch = 3'(c); cfg_kind = (c < 6) ? 3'(c) : ((c == 6) ? 3'd4 : 3'd5);
            tick();
        end
        ien_we = 1; ien_wdata = 6'b010000;
        tick();

        for (int i = 0; i < NV; i++) begin
            ev_valid = VEC[i].ev;  ev_ch = VEC[i].evc;
            ev_rset = VEC[i].rset; ev_wset = VEC[i].wset;
            cs_we = VEC[i].cs;     cs_wdata = VEC[i].csd;
            sw_we = VEC[i].sw;     sw_ch = VEC[i].swc;
            sw_rmask = VEC[i].swr; sw_wmask = VEC[i].sww;
            tick();
            chk($sformatf("vec %0d R2/R3 ch_status", i), 32'(ch_status), 32'(VEC[i].est));
            chk($sformatf("vec %0d R5 irq", i), 32'(irq), 32'(VEC[i].eirq));
            chk($sformatf("vec %0d R6-R9 halted", i), 32'(halted), 32'(VEC[i].ehalt));
        end

        // R10 readback
        rd_ch = 3'd2; #1;
        chk("R10 rd_rsts", 32'(rd_rsts), 32'h01);
        chk("R10 rd_wsts", 32'(rd_wsts), 32'h00);
        chk("R10 rd_kind", 32'(rd_kind), 32'd2);
        rd_ch = 3'd5; #1;
        chk("R10 rd_kind iso", 32'(rd_kind), 32'd5);
        rd_ch = 3'd2;

        // R4 ones keep, zeros clear
        sw_we = 1; sw_ch = 3'd2; sw_rmask = 8'hFF; sw_wmask = 8'hFF;
        tick();
        chk("R4 ones keep", 32'(rd_rsts), 32'h01);
        sw_we = 1; sw_ch = 3'd2; sw_rmask = 8'hFE; sw_wmask = 8'hFF;
        tick();
        chk("R4 zero clears", 32'(rd_rsts), 32'h00);

        // R4 event wins over same-cycle clear
        sw_we = 1; sw_ch = 3'd7; sw_rmask = 8'h00; sw_wmask = 8'h00;
        ev_valid = 1; ev_ch = 3'd7; ev_rset = 8'h00; ev_wset = 8'h02;
        tick();
        rd_ch = 3'd7; #1;
        chk("R4 event wins", 32'(rd_wsts), 32'h02);
        chk("R7 iso bit1 halts", 32'(halted), 32'h82);
        sw_we = 1; sw_ch = 3'd7; sw_rmask = 8'hFF; sw_wmask = 8'h00;
        cs_we = 1; cs_wdata = 8'h7F;
        tick();
        chk("R9 ch7 released", 32'(halted), 32'h02);
        chk("R3 ch7 cleared", 32'(ch_status), 32'h0A);

        // R5 enable selection (pending: ch1 ctl-rx, ch3 asy-rx)
        ien_we = 1; ien_wdata = 6'b000010;
        tick();
        chk("R5 ctl-rx enable", 32'(irq), 1);
        ien_we = 1; ien_wdata = 6'b001000;
        tick();
        chk("R5 asy-rx enable", 32'(irq), 1);
        ien_we = 1; ien_wdata = 6'b110101;
        tick();
        chk("R5 other enables", 32'(irq), 0);

        // R5 R8 unused kind codes
        ien_we = 1; ien_wdata = 6'b111111;
        cfg_we = 1; cfg_ch = 3'd1; cfg_kind = 3'd6;
        tick();
        chk("R8 kind 6 no halt", 32'(halted), 32'h00);
        chk("R5 ch3 still interrupts", 32'(irq), 1);
        cfg_we = 1; cfg_ch = 3'd3; cfg_kind = 3'd7;
        tick();
        chk("R5 kinds 6/7 no irq", 32'(irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule